// File: doc/BRIEF.md
# Exhaustive Key Search Sequencer

This block drives a brute-force search over the 56-bit key space of a block cipher. It holds five registers: a plaintext, a ciphertext, a start key, a progress key and a found key. A bus-side decoder delivers register accesses to it as a word index, byte strobes and data. Once the start key is written, the block hands out groups of consecutive candidate keys to a bank of encryption engines. It advances the progress register after each group that comes back without a match. When an engine reports a match, it captures the winning key and raises a one-cycle interrupt.

Software steers the block through the start-key words. A write to the low word halts any search in flight. A write to the high word begins a new search from the full start key, so the low word is written first and the high word second. Software can watch the search advance by reading the progress register, low word first. Four bits of that register also drive the LED pins.

The sequencer walks through four named states. IDLE waits for a start. PRIME loads the candidate counter from the start key. ISSUE presents one group of `N_ENG` keys to the engines for one cycle. WAIT holds until the engines return a result. The transitions are:
- start (any state to PRIME).
- stop (any state to IDLE).
- prime-done (PRIME to ISSUE).
- issued (ISSUE to WAIT).
- miss (WAIT to ISSUE, with progress and candidate advanced).
- hit (WAIT to IDLE, with found key and interrupt).

Start and stop take precedence over a result that arrives in the same cycle.

Top module: `keysearch_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, every register reads zero, `irq`, `eng_issue` and `led` are low, and no keys are issued until a start.
- R2: The word index selects the registers as follows. Indices 0/1 are plaintext low/high, 2/3 are ciphertext low/high, 4/5 are start-key low/high, 6/7 are progress low/high and 8/9 are found-key low/high. Writes to indices 0–5 update only the bytes whose strobe bit is set (strobe bit b covers data bits 8b+7..8b). Read data appears on `rd_data` one cycle after `rd_en`.
- R3: A write to index 4 stops the search, and no key is issued afterwards until the next write to index 5.
- R4: A write to index 5 starts a search at the start-key value. The progress register holds the largest key of the most recent group that completed with no match: start + k·N_ENG − 1 after k such groups. Progress is unchanged by a group that matches.
- R5: A read of index 6 freezes the progress register. It stays frozen, even as groups complete, until index 7 is read, and the two halves then form one consistent value.
- R6: On a match, the found-key register takes the matching key, `irq` is high for exactly one cycle, and no further keys are issued until a new start.
- R7: Candidate keys advance modulo 2^56, so a search passes from the all-ones key to zero and continues.
- R8: `led` equals bits 33..30 of the progress register.
- R9: Bits 31..24 of indices 5, 7 and 9 always read zero, and strobed writes to bits 31..24 of index 5 are discarded.
- R10: Each issue pulse lasts one cycle and presents keys `eng_base` + i for lanes i = 0..N_ENG−1. The next group is issued only after `eng_done`.
- R11: When several lanes report a hit in the same result, the key of the lowest-numbered lane becomes the found key.
- R12: Writes to indices 6 and above change no register, and reads of indices 10 and above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | synchronous reset, active low |
| wr_en | input | 1 | register write event |
| wr_idx | input | 4 | 32-bit word index of the write |
| wr_strb | input | 4 | byte enables of the write |
| wr_data | input | 32 | write data |
| rd_en | input | 1 | register read event |
| rd_idx | input | 4 | 32-bit word index of the read |
| rd_data | output | 32 | read data, valid the cycle after `rd_en` |
| eng_plain | output | 64 | plaintext for the engines |
| eng_cipher | output | 64 | ciphertext for the engines |
| eng_issue | output | 1 | one-cycle pulse presenting a key group |
| eng_base | output | 56 | first key of the group; lane i tests base + i |
| eng_done | input | 1 | result of the issued group is valid |
| eng_hit | input | N_ENG | per-lane match flags, valid with `eng_done` |
| irq | output | 1 | one-cycle pulse on a found key |
| led | output | 4 | progress bits 33..30 |

## Verification
The bench sweeps the match position across the first three groups after a start. A progress update taken one group too early or late shows up as an off-by-N_ENG progress value, and a wrong lane offset shows up as a wrong found key. Runs placed astride the all-ones key catch a counter that saturates or stalls instead of wrapping, and a double hit catches a priority encoder that favours the highest lane. The freeze run reads the low progress word twice across many completed groups: a design that keeps updating would return two different words. Stop-mid-search and post-match runs count issue pulses, so a sequencer that keeps issuing after a stop or after a hit is caught.

// File: rtl/ks_pkg.sv
package ks_pkg;
    localparam int KEY_W = 56;

    localparam logic [3:0] IDX_P_LO  = 4'd0;
    localparam logic [3:0] IDX_P_HI  = 4'd1;
    localparam logic [3:0] IDX_C_LO  = 4'd2;
    localparam logic [3:0] IDX_C_HI  = 4'd3;
    localparam logic [3:0] IDX_S_LO  = 4'd4;
    localparam logic [3:0] IDX_S_HI  = 4'd5;
    localparam logic [3:0] IDX_G_LO  = 4'd6;
    localparam logic [3:0] IDX_G_HI  = 4'd7;
    localparam logic [3:0] IDX_F_LO  = 4'd8;
    localparam logic [3:0] IDX_F_HI  = 4'd9;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PRIME,
        S_ISSUE,
        S_WAIT
    } ks_state_e;
endpackage

// File: rtl/ks_prio.sv
module ks_prio #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hit,
    output logic          any,
    output logic [IW-1:0] lane
);
    logic [N-1:0] win;

    for (genvar g = 0; g < N; g++) begin : g_win
        if (g == 0) begin : g_first
            assign win[g] = hit[g];
        end else begin : g_rest
            assign win[g] = hit[g] & ~(|hit[g-1:0]);
        end
    end

    always_comb begin
        lane = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i]) lane = lane | IW'(i);
        end
    end

    assign any = |hit;
endmodule

// File: rtl/ks_fsm.sv
module ks_fsm
    import ks_pkg::*;
#(
    parameter int N_ENG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [KEY_W-1:0] start_key,
    input  logic             done,
    input  logic [N_ENG-1:0] hit,
    output logic             issue,
    output logic [KEY_W-1:0] base,
    output logic [KEY_W-1:0] prog,
    output logic [KEY_W-1:0] found,
    output logic             irq
);
    localparam int IW = (N_ENG > 1) ? $clog2(N_ENG) : 1;
    localparam logic [KEY_W-1:0] STEP = KEY_W'(N_ENG);

    ks_state_e state_q, state_d;
    logic [KEY_W-1:0] cand_q;
    logic             hit_any;
    logic [IW-1:0]    hit_lane;

    ks_prio #(.N(N_ENG)) u_prio (
        .hit  (hit),
        .any  (hit_any),
        .lane (hit_lane)
    );

    // Next-state logic: start and stop override everything.
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = S_IDLE;
        end else if (start) begin
            state_d = S_PRIME;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_PRIME: state_d = S_ISSUE;
                S_ISSUE: state_d = S_WAIT;
                S_WAIT:  if (done) state_d = hit_any ? S_IDLE : S_ISSUE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Key datapath and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
            prog   <= '0;
            found  <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!stop && !start) begin
                if (state_q == S_PRIME) begin
                    cand_q <= start_key;
                end else if (state_q == S_WAIT && done) begin
                    if (hit_any) begin
                        found <= cand_q + KEY_W'(hit_lane);
                        irq   <= 1'b1;
                    end else begin
                        prog   <= cand_q + STEP - KEY_W'(1);
                        cand_q <= cand_q + STEP;
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        issue = (state_q == S_ISSUE);
        base  = cand_q;
    end
endmodule

// File: rtl/keysearch_ctrl.sv
module keysearch_ctrl
    import ks_pkg::*;
#(
    parameter int N_ENG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_idx,
    input  logic [3:0]       wr_strb,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [3:0]       rd_idx,
    output logic [31:0]      rd_data,
    output logic [63:0]      eng_plain,
    output logic [63:0]      eng_cipher,
    output logic             eng_issue,
    output logic [KEY_W-1:0] eng_base,
    input  logic             eng_done,
    input  logic [N_ENG-1:0] eng_hit,
    output logic             irq,
    output logic [3:0]       led
);
    logic [63:0]      pt_q, ct_q;
    logic [KEY_W-1:0] sk_q, view_q, prog, found;
    logic             frz_q;
    logic             start, stop, rd_lo, rd_hi;
    logic [31:0]      rd_mux;

    function automatic logic [31:0] merge(input logic [31:0] old,
                                          input logic [31:0] nw,
                                          input logic [3:0]  be);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        end
        return r;
    endfunction

    assign stop  = wr_en && (wr_idx == IDX_S_LO);
    assign start = wr_en && (wr_idx == IDX_S_HI);
    assign rd_lo = rd_en && (rd_idx == IDX_G_LO);
    assign rd_hi = rd_en && (rd_idx == IDX_G_HI);

    ks_fsm #(.N_ENG(N_ENG)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .start_key (sk_q),
        .done      (eng_done),
        .hit       (eng_hit),
        .issue     (eng_issue),
        .base      (eng_base),
        .prog      (prog),
        .found     (found),
        .irq       (irq)
    );

    // Writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
            ct_q <= '0;
            sk_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_P_LO: pt_q[31:0]  <= merge(pt_q[31:0],  wr_data, wr_strb);
                IDX_P_HI: pt_q[63:32] <= merge(pt_q[63:32], wr_data, wr_strb);
                IDX_C_LO: ct_q[31:0]  <= merge(ct_q[31:0],  wr_data, wr_strb);
                IDX_C_HI: ct_q[63:32] <= merge(ct_q[63:32], wr_data, wr_strb);
                IDX_S_LO: sk_q[31:0]  <= merge(sk_q[31:0],  wr_data, wr_strb);
                IDX_S_HI: sk_q[55:32] <= merge({8'h00, sk_q[55:32]}, wr_data,
                                               {1'b0, wr_strb[2:0]})[23:0];
                default: ;
            endcase
        end
    end

    // Progress view with read freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view_q <= '0;
            frz_q  <= 1'b0;
        end else begin
            if (!(frz_q || rd_lo)) view_q <= prog;
            if (rd_lo)      frz_q <= 1'b1;
            else if (rd_hi) frz_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_idx)
            IDX_P_LO: rd_mux = pt_q[31:0];
            IDX_P_HI: rd_mux = pt_q[63:32];
            IDX_C_LO: rd_mux = ct_q[31:0];
            IDX_C_HI: rd_mux = ct_q[63:32];
            IDX_S_LO: rd_mux = sk_q[31:0];
            IDX_S_HI: rd_mux = {8'h00, sk_q[55:32]};
            IDX_G_LO: rd_mux = view_q[31:0];
            IDX_G_HI: rd_mux = {8'h00, view_q[55:32]};
            IDX_F_LO: rd_mux = found[31:0];
            IDX_F_HI: rd_mux = {8'h00, found[55:32]};
            default:  rd_mux = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign eng_plain  = pt_q;
    assign eng_cipher = ct_q;
    assign led        = view_q[33:30];
endmodule

// File: rtl/ks_checker.sv
module ks_checker #(
    parameter int N_ENG = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic        rd_en,
    input logic [3:0]  rd_idx,
    input logic [31:0] rd_data,
    input logic        eng_issue,
    input logic        irq,
    input logic [3:0]  led
);
    logic frz_m;

    always_ff @(posedge clk) begin
        if (!rst_n)                          frz_m <= 1'b0;
        else if (rd_en && rd_idx == 4'd6)    frz_m <= 1'b1;
        else if (rd_en && rd_idx == 4'd7)    frz_m <= 1'b0;
    end

    p_stop_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd4) |=> !eng_issue);

    p_frozen_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en && rd_idx == 4'd6) || (frz_m && !(rd_en && rd_idx == 4'd7)))
        |=> $stable(led));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !eng_issue);

    p_top_byte_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_idx == 4'd5 || rd_idx == 4'd7 || rd_idx == 4'd9))
        |=> (rd_data[31:24] == 8'h00));

    p_issue_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_issue |=> !eng_issue);
endmodule

bind keysearch_ctrl ks_checker #(.N_ENG(N_ENG)) u_ks_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .eng_issue (eng_issue),
    .irq       (irq),
    .led       (led)
);

// File: tb/test_keysearch_ctrl.sv
module eng_stub #(
    parameter int N   = 4,
    parameter int LAT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue,
    input  logic [55:0] base,
    input  logic [55:0] tgt_a,
    input  logic [55:0] tgt_b,
    output logic        done,
    output logic [N-1:0] hit
);
    int           cnt;
    logic [N-1:0] h_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= 0;
            h_q  <= '0;
            done <= 1'b0;
        end else if (issue) begin
            cnt  <= LAT;
            done <= 1'b0;
            for (int i = 0; i < N; i++)
                h_q[i] <= ((base + 56'(i)) == tgt_a) || ((base + 56'(i)) == tgt_b);
        end else if (cnt != 0) begin
            cnt  <= cnt - 1;
            done <= (cnt == 1);
        end else begin
            done <= 1'b0;
        end
    end

    assign hit = done ? h_q : '0;
endmodule

module test_keysearch_ctrl;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  wr_idx = '0, wr_strb = '0, rd_idx = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [63:0] eng_plain, eng_cipher;
    logic        eng_issue, eng_done, irq;
    logic [55:0] eng_base;
    logic [N-1:0] eng_hit;
    logic [3:0]  led;
    logic [55:0] tgt_a = '1, tgt_b = '1;

    int tests = 0, fails = 0;
    int irq_cnt = 0, issue_cnt = 0, miss_cnt = 0;

    always #4 clk = ~clk;

    keysearch_ctrl #(.N_ENG(N)) i_keysearch_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_strb(wr_strb), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .eng_plain(eng_plain), .eng_cipher(eng_cipher),
        .eng_issue(eng_issue), .eng_base(eng_base),
        .eng_done(eng_done), .eng_hit(eng_hit),
        .irq(irq), .led(led)
    );

    eng_stub #(.N(N), .LAT(3)) u_stub (
        .clk(clk), .rst_n(rst_n), .issue(eng_issue), .base(eng_base),
        .tgt_a(tgt_a), .tgt_b(tgt_b), .done(eng_done), .hit(eng_hit)
    );

    always @(negedge clk) begin
        if (irq)       irq_cnt++;
        if (eng_issue) issue_cnt++;
        if (eng_done && eng_hit == '0) miss_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d,
                      input logic [3:0] be = 4'hF);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_strb = be;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd64(input logic [3:0] idx, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(idx, lo);
        rd(idx + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_search(input logic [55:0] k0);
        wr(4'd4, k0[31:0]);
        wr(4'd5, {8'hA5, k0[55:32]});
    endtask

    // Full search: returns found key, progress and miss groups.
    task automatic run_search(input logic [55:0] k0, input logic [55:0] ta,
                              input logic [55:0] tb, input string tag,
                              output logic [63:0] fk, output logic [63:0] pg,
                              output int groups);
        int i0, s0;
        i0 = irq_cnt;
        start_search(k0);
        miss_cnt = 0;
        tgt_a = ta; tgt_b = tb;
        for (int t = 0; t < 3000 && irq_cnt == i0; t++) @(negedge clk);
        idle(6);
        chk(irq_cnt == i0 + 1, {tag, " R6 irq one pulse"}, 64'(irq_cnt - i0), 64'd1);
        s0 = issue_cnt;
        idle(30);
        chk(issue_cnt == s0, {tag, " R6 halt after match"}, 64'(issue_cnt - s0), 64'd0);
        groups = miss_cnt;
        rd64(4'd8, fk);
        rd64(4'd6, pg);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] v, fk, pg, prev;
        int groups;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(irq == 0 && eng_issue == 0 && led == 0, "R1 outputs idle",
            {irq, eng_issue, led}, 0);
        for (int i = 0; i < 10; i++) begin
            rd(4'(i), d);
            chk(d == 0, "R1 register zero", d, 0);
        end
        idle(10);
        chk(issue_cnt == 0, "R1 no issue before start", issue_cnt, 0);

        // R2: registers and strobes
        wr(4'd0, 32'h11223344);
        wr(4'd1, 32'h55667788);
        wr(4'd2, 32'hDEADBEEF);
        wr(4'd3, 32'hFFFFFFFF, 4'b0101);
        rd64(4'd0, v);
        chk(v == 64'h55667788_11223344 && eng_plain == v, "R2 plaintext", v,
            64'h55667788_11223344);
        rd64(4'd2, v);
        chk(v == 64'h00FF00FF_DEADBEEF && eng_cipher == v, "R2 ciphertext strobes",
            v, 64'h00FF00FF_DEADBEEF);

        // R12: read-only and unmapped writes / reads
        wr(4'd8, 32'hCAFEF00D);
        wr(4'd9, 32'hCAFEF00D);
        wr(4'd6, 32'h12345678);
        wr(4'd12, 32'h12345678);
        rd64(4'd8, v);
        chk(v == 0, "R12 found key not writable", v, 0);
        rd64(4'd6, v);
        chk(v == 0, "R12 progress not writable", v, 0);
        rd(4'd12, d);
        chk(d == 0, "R12 unmapped read zero", d, 0);
        rd64(4'd0, v);
        chk(v == 64'h55667788_11223344, "R12 plaintext untouched", v,
            64'h55667788_11223344);

        // R9: top byte of start key
        wr(4'd4, 32'h0);
        wr(4'd5, 32'hFF00_0000, 4'b1000);
        rd(4'd5, d);
        chk(d == 0, "R9 start-key top byte discarded", d, 0);
        wr(4'd4, 32'h0);
        idle(10);

        // R4/R6/R10: sweep of hit position over the first three groups
        prev = 0;
        for (int off = 0; off < 12; off++) begin
            logic [55:0] k0;
            int exp_g;
            k0 = 56'h1000 + 56'(off * 7);
            exp_g = off / N;
            run_search(k0, k0 + 56'(off), k0 + 56'(off), "sweep", fk, pg, groups);
            chk(fk == 64'(k0 + 56'(off)), "R6 found key", fk, 64'(k0 + 56'(off)));
            chk(groups == exp_g, "R10 groups before match", groups, exp_g);
            if (exp_g > 0) prev = 64'(k0 + 56'(exp_g * N) - 56'd1);
            chk(pg == prev, "R4 progress value", pg, prev);
        end

        // R11: two lanes hit together
        run_search(56'h20, 56'h22, 56'h21, "prio", fk, pg, groups);
        chk(fk == 64'h21, "R11 lowest lane wins", fk, 64'h21);

        // R7: wrap across all-ones, also R9 (top byte written as A5)
        run_search(56'hFF_FFFF_FFFF_FFFA, 56'h1, 56'h1, "wrap", fk, pg, groups);
        chk(fk == 64'h1, "R7 found after wrap", fk, 64'h1);
        chk(pg == 64'h00FF_FFFF_FFFF_FFFD, "R7 progress before wrap", pg,
            64'h00FF_FFFF_FFFF_FFFD);
        rd(4'd5, d);
        chk(d == 32'h00FFFFFF, "R9 start-key high read", d, 32'h00FFFFFF);

        // R8: led from progress bits 33..30
        run_search(56'h4000_0000, 56'h4000_000A, 56'h4000_000A, "led", fk, pg, groups);
        chk(pg == 64'h4000_0007, "R4 progress near bit 30", pg, 64'h4000_0007);
        chk(led == 4'h1, "R8 led bits", led, 4'h1);

        // R5: freeze during a long search
        tgt_a = 56'h0; tgt_b = 56'h0;
        start_search(56'd100);
        idle(40);
        begin
            logic [31:0] a1, a2, a3, b;
            logic [63:0] full;
            rd(4'd6, a1);
            idle(60);
            rd(4'd6, a2);
            chk(a2 == a1, "R5 low word frozen", a2, a1);
            rd(4'd7, b);
            full = {b, a1};
            chk(full >= 64'd103 && ((full - 64'd99) % N) == 0,
                "R5 consistent progress", full, 64'd103);
            idle(60);
            rd(4'd6, a3);
            chk(a3 != a1, "R5 update resumes", a3, a1 + 1);
            rd(4'd7, b);
        end

        // R3: stop mid-search
        wr(4'd4, 32'd100);
        idle(10);
        begin
            int s0, i0;
            s0 = issue_cnt; i0 = irq_cnt;
            idle(60);
            chk(issue_cnt == s0, "R3 no issue after stop", issue_cnt - s0, 0);
            chk(irq_cnt == i0, "R3 no irq after stop", irq_cnt - i0, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule